// File: doc/BRIEF.md
# Banked GPIO Controller with Shared Interrupt

This block is a memory-mapped general-purpose I/O controller built from a parameterised number of banks. Each bank carries up to 32 pins, and its configured width sets how many of those pins are live. Every bank has eight 32-bit registers behind a simple word-addressed read/write port. These registers hold the output latch, the pin direction, open-drain selection, the trigger type for each pin, an interrupt mask and a sticky status word.

Input pins pass through a two-stage synchroniser. The controller then compares the synchronised sample with the one before it to find edges, or reads the sample directly for level-sensitive pins. Detected events latch into the status register, and software clears them by writing ones. A single interrupt line rises whenever any bank holds a status bit whose mask bit is also set. Software reads and writes the registers through the port. The pad side uses separate input, output-value and output-enable vectors, 32 bits per bank.

Top module: `banked_gpio_irq`

## Requirements
- R1: Bank N occupies byte addresses N*0x20 to N*0x20+0x1F. Within a bank, the register offsets are: 0x00 open-drain select, 0x04 data, 0x08 direction, 0x0C edge polarity, 0x10 both-edge select, 0x14 interrupt mask, 0x18 level select and 0x1C status. An address with nonzero bits [1:0], or a bank index of NUM_BANKS or more, reads back zero, and a write to it changes no register.
- R2: A direction bit of 1 makes the pin an input with its output enable low. A direction bit of 0 makes it an output. A push-pull output (open-drain bit 0) drives its data bit with the output enable high.
- R3: An output pin with its open-drain bit set drives 0 with the output enable high when its data bit is 0. When its data bit is 1, the output enable is low (the pin is released). An open-drain pin never drives a 1.
- R4: Reading the data register returns, per bit, the synchronised pin value for inputs and the output latch for outputs. A pin change becomes visible in a read after two rising clock edges.
- R5: When a pin's level bit is 0, a both-edge bit of 1 latches status on either edge and ignores the edge polarity bit. Otherwise an edge polarity of 1 latches on rising edges and 0 latches on falling edges. The status bit is visible after the third rising clock edge that follows the pin change.
- R6: When a pin's level bit is 1, status latches while the synchronised pin is high. A clear has no effect while the pin stays high, so the bit stays set.
- R7: Writing the status register clears each bit written as 1 and leaves each bit written as 0 unchanged. When a new event arrives in the same cycle as a clear, the event wins.
- R8: In a bank of width W, register bits at positions W and above read 0, ignore writes, never set status and never drive the pad.
- R9: The interrupt output is high exactly when some bank has a bit set in both its status and its mask.
- R10: After reset the direction register of each bank holds ones in all valid bit positions, so every pin is an input. All other registers are zero, so every interrupt is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busAddr | input | ADDR_W | Byte address of the register access |
| busWrEn | input | 1 | Write strobe for one cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| pinIn | input | 32*NUM_BANKS | Pad input values, bank N at bits [32N+31:32N] |
| pinOut | output | 32*NUM_BANKS | Value driven toward the pads |
| pinOe | output | 32*NUM_BANKS | Per-pin output enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that a pin is only updated through the bus once reset has been released, and that pad inputs are held low during reset. That way the synchroniser starts from a known value, and the first sample after reset cannot count as an edge. The stimulus changes pins only on the falling clock edge and holds them for at least four cycles before status is checked. In each random pass, the other bank's mask is first set to zero, so the expected interrupt depends only on the bank under test.

// File: rtl/bgpio_pkg.sv
`timescale 1ns/1ps
package bgpio_pkg;

  localparam int REG_W = 32;

  // Register slot inside a bank window, taken from address bits [4:2].
  typedef enum logic [2:0] {
    REG_ODRAIN = 3'd0,
    REG_DATA   = 3'd1,
    REG_DIR    = 3'd2,
    REG_EDGE   = 3'd3,
    REG_BOTH   = 3'd4,
    REG_MASK   = 3'd5,
    REG_LEVEL  = 3'd6,
    REG_STAT   = 3'd7
  } regSel_e;

  // One write strobe per register, sent from the decoder to a bank.
  typedef struct packed {
    logic wrOdrain;
    logic wrData;
    logic wrDir;
    logic wrEdge;
    logic wrBoth;
    logic wrMask;
    logic wrLevel;
    logic clrStat;
  } bankStrobe_t;

  function automatic logic [REG_W-1:0] widthMask(int unsigned w);
    logic [REG_W-1:0] m;
    for (int i = 0; i < REG_W; i++) begin
      m[i] = (i < int'(w));
    end
    return m;
  endfunction

endpackage

// File: rtl/bgpio_decode.sv
`timescale 1ns/1ps
module bgpio_decode
  import bgpio_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [ADDR_W-1:0]               busAddr,
  input  logic                            busWrEn,
  output bankStrobe_t [NUM_BANKS-1:0]     strobes,
  output logic [ADDR_W-6:0]               rdBank,
  output regSel_e                         rdReg,
  output logic                            rdHit
);

  localparam int BANK_IDX_W = ADDR_W - 5;

  logic [BANK_IDX_W-1:0] bankIdx;
  logic                  aligned;
  logic                  inRange;

  assign bankIdx = busAddr[ADDR_W-1:5];
  assign aligned = (busAddr[1:0] == 2'b00);
  assign inRange = (32'(bankIdx) < NUM_BANKS);
  assign rdHit   = aligned && inRange;
  assign rdBank  = bankIdx;
  assign rdReg   = regSel_e'(busAddr[4:2]);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_strobe
    logic selWr;
    assign selWr = busWrEn && rdHit && (32'(bankIdx) == b);
    always_comb begin
      strobes[b]          = '0;
      strobes[b].wrOdrain = selWr && (rdReg == REG_ODRAIN);
      strobes[b].wrData   = selWr && (rdReg == REG_DATA);
      strobes[b].wrDir    = selWr && (rdReg == REG_DIR);
      strobes[b].wrEdge   = selWr && (rdReg == REG_EDGE);
      strobes[b].wrBoth   = selWr && (rdReg == REG_BOTH);
      strobes[b].wrMask   = selWr && (rdReg == REG_MASK);
      strobes[b].wrLevel  = selWr && (rdReg == REG_LEVEL);
      strobes[b].clrStat  = selWr && (rdReg == REG_STAT);
    end
  end

  // R1: a bus write reaches at most one register in one bank
  a_r1_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(strobes) <= 1);

  // R1: no strobe without a write on the port
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busWrEn |-> (strobes == '0));

endmodule

// File: rtl/bgpio_bank.sv
`timescale 1ns/1ps
module bgpio_bank
  import bgpio_pkg::*;
#(
  parameter int PIN_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bankStrobe_t       strobe,
  input  logic [REG_W-1:0]  wdata,
  input  regSel_e           rdReg,
  input  logic [REG_W-1:0]  pinIn,
  output logic [REG_W-1:0]  rdWord,
  output logic [REG_W-1:0]  pinOut,
  output logic [REG_W-1:0]  pinOe,
  output logic              irqReq
);

  localparam logic [REG_W-1:0] VALID = widthMask(PIN_W);

  logic [REG_W-1:0] odReg, dataReg, dirReg, edgeReg, bothReg;
  logic [REG_W-1:0] maskReg, levelReg, statReg;
  logic [REG_W-1:0] syncA, syncB, syncPrev;
  logic [REG_W-1:0] rise, fall, edgeHit, trig, clrVec, wMasked;

  assign wMasked = wdata & VALID;

  // Configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      odReg    <= '0;
      dataReg  <= '0;
      dirReg   <= VALID;
      edgeReg  <= '0;
      bothReg  <= '0;
      maskReg  <= '0;
      levelReg <= '0;
    end else begin
      if (strobe.wrOdrain) odReg    <= wMasked;
      if (strobe.wrData)   dataReg  <= wMasked;
      if (strobe.wrDir)    dirReg   <= wMasked;
      if (strobe.wrEdge)   edgeReg  <= wMasked;
      if (strobe.wrBoth)   bothReg  <= wMasked;
      if (strobe.wrMask)   maskReg  <= wMasked;
      if (strobe.wrLevel)  levelReg <= wMasked;
    end
  end

  // Two-stage synchroniser plus history stage for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncA    <= '0;
      syncB    <= '0;
      syncPrev <= '0;
    end else begin
      syncA    <= pinIn & VALID;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  assign rise    = syncB & ~syncPrev;
  assign fall    = ~syncB & syncPrev;
  assign edgeHit = (bothReg & (rise | fall))
                 | (~bothReg & edgeReg & rise)
                 | (~bothReg & ~edgeReg & fall);
  assign trig    = ((levelReg & syncB) | (~levelReg & edgeHit)) & VALID;
  assign clrVec  = strobe.clrStat ? wdata : '0;

  // Sticky status: set beats clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) statReg <= '0;
    else        statReg <= (statReg & ~clrVec) | trig;
  end

  // Pad drive
  assign pinOe  = VALID & ~dirReg & (~odReg | ~dataReg);
  assign pinOut = VALID & ~dirReg & ~odReg & dataReg;

  assign irqReq = |(statReg & maskReg);

  always_comb begin
    unique case (rdReg)
      REG_ODRAIN: rdWord = odReg;
      REG_DATA:   rdWord = ((dirReg & syncB) | (~dirReg & dataReg)) & VALID;
      REG_DIR:    rdWord = dirReg;
      REG_EDGE:   rdWord = edgeReg;
      REG_BOTH:   rdWord = bothReg;
      REG_MASK:   rdWord = maskReg;
      REG_LEVEL:  rdWord = levelReg;
      REG_STAT:   rdWord = statReg;
      default:    rdWord = '0;
    endcase
  end

  // R7: bits not written with 1 are never lost
  a_r7_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(statReg & ~clrVec) & ~statReg) == '0));

  // R6: an active level source is reflected in status on the next cycle
  a_r6_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(levelReg & syncB & VALID) & ~statReg) == '0));

  // R5: both-edge pins latch either transition
  a_r5_both_edge: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past((rise | fall) & bothReg & ~levelReg & VALID) & ~statReg) == '0));

  // R3: an open-drain pin never drives a one
  a_r3_od_no_high: assert property (@(posedge clk) disable iff (!rst_n)
    ((pinOe & pinOut & odReg) == '0));

  // R9: no request while the mask is all zero
  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (maskReg == '0) |-> !irqReq);

  // R8: pads above the bank width stay undriven
  a_r8_upper_undriven: assert property (@(posedge clk) disable iff (!rst_n)
    ((pinOe & ~VALID) == '0));

endmodule

// File: rtl/banked_gpio_irq.sv
`timescale 1ns/1ps
module banked_gpio_irq
  import bgpio_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 8,
  parameter logic [8*NUM_BANKS-1:0] BANK_WIDTHS = {8'd20, 8'd32}
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         busAddr,
  input  logic                      busWrEn,
  input  logic [31:0]               busWdata,
  output logic [31:0]               busRdata,
  input  logic [32*NUM_BANKS-1:0]   pinIn,
  output logic [32*NUM_BANKS-1:0]   pinOut,
  output logic [32*NUM_BANKS-1:0]   pinOe,
  output logic                      irq
);

  bankStrobe_t [NUM_BANKS-1:0] strobes;
  logic [ADDR_W-6:0]           rdBank;
  regSel_e                     rdReg;
  logic                        rdHit;
  logic [31:0]                 bankWord [NUM_BANKS];
  logic [NUM_BANKS-1:0]        irqBank;

  bgpio_decode #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W)
  ) u_decode (
    .clk     (clk),
    .rst_n   (rst_n),
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobes (strobes),
    .rdBank  (rdBank),
    .rdReg   (rdReg),
    .rdHit   (rdHit)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int PW = int'(BANK_WIDTHS[8*b +: 8]);
    bgpio_bank #(.PIN_W(PW)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (strobes[b]),
      .wdata  (busWdata),
      .rdReg  (rdReg),
      .pinIn  (pinIn[32*b +: 32]),
      .rdWord (bankWord[b]),
      .pinOut (pinOut[32*b +: 32]),
      .pinOe  (pinOe[32*b +: 32]),
      .irqReq (irqBank[b])
    );
  end

  always_comb begin
    busRdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (rdHit && (32'(rdBank) == b)) busRdata = bankWord[b];
    end
  end

  assign irq = |irqBank;

endmodule

// File: tb/banked_gpio_irq_test.sv
`timescale 1ns/1ps
module banked_gpio_irq_test;

  localparam int NB = 2;
  localparam logic [31:0] VAL0 = 32'hFFFF_FFFF;
  localparam logic [31:0] VAL1 = 32'h000F_FFFF;
  localparam int R_OD = 0, R_DATA = 1, R_DIR = 2, R_EDGE = 3,
                 R_BOTH = 4, R_MASK = 5, R_LEVEL = 6, R_STAT = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    busAddr = '0;
  logic          busWrEn = 1'b0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic [63:0]   pinIn = '0;
  logic [63:0]   pinOut, pinOe;
  logic          irq;

  int checks = 0;
  int errors = 0;

  banked_gpio_irq uut (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .irq(irq)
  );

  always #2 clk = ~clk;

  function automatic logic [31:0] validOf(int b);
    return (b == 0) ? VAL0 : VAL1;
  endfunction

  function automatic logic [31:0] expEvt(logic [31:0] a, logic [31:0] n,
      logic [31:0] ec, logic [31:0] ei, logic [31:0] lv, logic [31:0] v);
    logic [31:0] r, f, e;
    r = n & ~a;
    f = a & ~n;
    e = (ei & (r | f)) | (~ei & ec & r) | (~ei & ~ec & f);
    return ((lv & (a | n)) | (~lv & e)) & v;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wrA(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic peek(logic [7:0] a, output logic [31:0] v);
    busAddr = a;
    #1;
    v = busRdata;
  endtask

  task automatic rdA(logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    peek(a, v);
  endtask

  task automatic wr(int b, int r, logic [31:0] d);
    wrA(8'(b * 32 + r * 4), d);
  endtask

  task automatic rd(int b, int r, output logic [31:0] v);
    rdA(8'(b * 32 + r * 4), v);
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, a, n, ec, ei, lv, mk, exp;
    void'($urandom(32'd4242));
    cyc(3);
    rst_n = 1'b1;
    cyc(2);

    // R10: reset values
    for (int b = 0; b < NB; b++) begin
      for (int r = 0; r < 8; r++) begin
        rd(b, r, v);
        check((r == R_DIR) ? "R10 dir reset" : "R10 reg reset", 64'(v),
              (r == R_DIR) ? 64'(validOf(b)) : 64'd0);
      end
    end
    check("R10 irq reset", 64'(irq), 64'd0);
    check("R2 no drive after reset", pinOe, 64'd0);

    // R1 and R8: readback and width masking
    wr(1, R_MASK, 32'hFFFF_FFFF);
    rd(1, R_MASK, v);
    check("R8 upper mask bits", 64'(v), 64'(VAL1));
    wr(1, R_MASK, 32'h0);
    wr(0, R_EDGE, 32'h1234_5678);
    rd(0, R_EDGE, v);
    check("R1 edge reg readback", 64'(v), 64'h1234_5678);
    wrA(8'h0D, 32'hFFFF_FFFF);
    rd(0, R_EDGE, v);
    check("R1 unaligned write ignored", 64'(v), 64'h1234_5678);
    rdA(8'h0D, v);
    check("R1 unaligned read zero", 64'(v), 64'd0);
    wrA(8'h4C, 32'h0);
    rd(0, R_EDGE, v);
    check("R1 unmapped bank write ignored", 64'(v), 64'h1234_5678);
    rdA(8'h4C, v);
    check("R1 unmapped bank read zero", 64'(v), 64'd0);
    wr(0, R_EDGE, 32'h0);

    // R2 and R3: pad drive
    wr(0, R_DATA, 32'h0000_00A5);
    wr(0, R_OD, 32'h0000_000F);
    wr(0, R_DIR, 32'hFFFF_FF00);
    @(negedge clk); #1;
    check("R3 open-drain enable", pinOe, 64'h0000_0000_0000_00FA);
    check("R2 push-pull value", pinOut, 64'h0000_0000_0000_00A0);

    // R4: data readback mix
    pinIn[31:0] = 32'h5A5A_5AFF;
    cyc(1);
    peek(8'h04, v);
    check("R4 not yet visible", 64'(v), 64'h0000_00A5);
    cyc(1);
    peek(8'h04, v);
    check("R4 mixed readback", 64'(v), 64'h5A5A_5AA5);
    wr(0, R_DIR, 32'hFFFF_FFFF);
    wr(0, R_OD, 32'h0);
    pinIn[31:0] = 32'h0;
    cyc(4);
    wr(0, R_STAT, 32'hFFFF_FFFF);

    // R5: rising edge latency
    wr(0, R_EDGE, 32'h0000_0200);
    pinIn[9] = 1'b1;
    cyc(2);
    peek(8'h1C, v);
    check("R5 status before third edge", 64'(v), 64'd0);
    cyc(1);
    peek(8'h1C, v);
    check("R5 status after third edge", 64'(v), 64'h200);

    // R7: write zero keeps, write one clears
    wr(0, R_STAT, 32'h0);
    rd(0, R_STAT, v);
    check("R7 zero write keeps", 64'(v), 64'h200);
    wr(0, R_STAT, 32'h200);
    rd(0, R_STAT, v);
    check("R7 one write clears", 64'(v), 64'd0);

    // R6: level source survives clears
    wr(1, R_LEVEL, 32'h8);
    pinIn[32+3] = 1'b1;
    cyc(4);
    wr(1, R_STAT, 32'h8);
    peek(8'h3C, v);
    check("R6 level re-asserts after clear", 64'(v), 64'h8);
    wr(1, R_MASK, 32'h8);
    #1;
    check("R9 irq with mask", 64'(irq), 64'd1);
    pinIn[32+3] = 1'b0;
    cyc(4);
    wr(1, R_STAT, 32'h8);
    rd(1, R_STAT, v);
    check("R6 clears once inactive", 64'(v), 64'd0);
    check("R9 irq drops", 64'(irq), 64'd0);
    wr(1, R_MASK, 32'h0);
    wr(1, R_LEVEL, 32'h0);

    // R8: pins above width
    wr(1, R_BOTH, 32'hFFFF_FFFF);
    pinIn[32+25] = 1'b1;
    cyc(4);
    pinIn[32+25] = 1'b0;
    cyc(4);
    rd(1, R_STAT, v);
    check("R8 upper pin no status", 64'(v), 64'd0);

    // Random passes: R5, R6, R9
    for (int it = 0; it < 40; it++) begin
      int b, o;
      b = it % 2;
      o = 1 - b;
      wr(o, R_MASK, 32'h0);
      wr(b, R_LEVEL, 32'h0);
      a = $urandom();
      pinIn[32*b +: 32] = a;
      cyc(4);
      wr(b, R_STAT, 32'hFFFF_FFFF);
      rd(b, R_STAT, v);
      check("R7 random clear", 64'(v), 64'd0);
      ec = $urandom(); ei = $urandom(); lv = $urandom() & $urandom();
      mk = $urandom();
      wr(b, R_EDGE, ec);
      wr(b, R_BOTH, ei);
      wr(b, R_LEVEL, lv);
      wr(b, R_MASK, mk);
      n = $urandom();
      pinIn[32*b +: 32] = n;
      cyc(4);
      exp = expEvt(a & validOf(b), n & validOf(b), ec, ei, lv, validOf(b));
      rd(b, R_STAT, v);
      check("R5 R6 random status", 64'(v), 64'(exp));
      check("R9 random irq", 64'(irq), 64'(|(exp & mk)));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule